// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block keeps a 64-bit time base that advances at a programmable fraction of its input clock. A 16-bit divider sets the rate: the count steps once every divider+1 clocks. The count is never halted. It runs through the whole 64-bit range and rolls over to zero.

Software on a 32-bit bus cannot read the running count in one access. The two halves of a direct read may belong to different count values. To avoid this, a command on the control register copies all 64 bits into a pair of snapshot registers in a single edge. Software then reads those two words at leisure.

A second command on the same register replaces the count with a 64-bit value staged beforehand in two preload registers. The bus has no handshake. A write takes effect at the clock edge where it is presented, and read data is a combinational function of the address.

Top module: `snap_counter64`

## Requirements
- R1: Under reset the count, divider, preload words and snapshot words are all zero, and every register reads zero.
- R2: With divider D in control bits [31:16], the count advances by exactly one once every D+1 clocks, counted from the last load command; D=0 advances it on every clock.
- R3: The count spans 64 bits, carries from the low word into the high word, and steps from all ones to zero.
- R4: A control write with bit 0 = 1 and bit 1 = 0 copies the count present in the write cycle into the snapshot low and high words at that edge.
- R5: A control write with bit 0 = 1 and bit 1 = 1 makes the count equal to the preload value at that edge. It restarts the divider phase, and a divider step due at the same edge is discarded.
- R6: The snapshot words keep their value until the next snapshot command; load commands and preload writes leave them unchanged.
- R7: Control bits 1:0 read back as zero, and no command stops counting. A control write with bit 0 = 0 only updates the divider field, whatever bit 1 holds.
- R8: Register map (byte offsets): 0x00 control, 0x04 live count low, 0x08 live count high, 0x0C preload low, 0x10 preload high, 0x14 snapshot low, 0x18 snapshot high. Preload words are read/write. Live and snapshot words are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situations to reach are a command that lands exactly on a divider step and a snapshot taken at an arbitrary phase of the divider. A wrong answer in either case differs from the right one by a single count. The bench sweeps several dividers and preload values, and issues every load with the divider set in the same write. This pins the phase to a known edge number, so the expected count at any later edge is preload + floor(edges / (D+1)). Snapshots are taken at many offsets within that phase, and carry and wrap are reached by preloading values just below a 32-bit boundary and just below all ones.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DIV_LSB  = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LIVE_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_LIVE_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_PRE_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PRE_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SNAP_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SNAP_HI = 8'h18;

    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_LOAD_BIT = 1;
endpackage

// File: rtl/scnt_prescale.sv
module scnt_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;

    assign tick_o = (pre_q.phase >= div_i);

    always_comb begin
        pre_d = pre_q;
        if (restart_i || tick_o) begin
            pre_d.phase = '0;
        end else begin
            pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/scnt_core.sv
module scnt_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             latch_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] snap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] snap;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (load_i) begin
            core_d.count = preload_i;
        end else if (tick_i) begin
            core_d.count = core_q.count + 1'b1;
        end
        if (latch_i) begin
            core_d.snap = core_q.count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign count_o = core_q.count;
    assign snap_o  = core_q.snap;
endmodule

// File: rtl/scnt_regs.sv
module scnt_regs
    import scnt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  snap_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [CNT_W-1:0]  preload_o,
    output logic              load_o,
    output logic              latch_o
);
    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [HALF_W-1:0] pre_lo;
        logic [HALF_W-1:0] pre_hi;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_hit;

    assign ctrl_hit = wr_i && (addr_i == OFF_CTRL);
    assign latch_o  = ctrl_hit && wdata_i[CMD_GO_BIT] && !wdata_i[CMD_LOAD_BIT];
    assign load_o   = ctrl_hit && wdata_i[CMD_GO_BIT] &&  wdata_i[CMD_LOAD_BIT];

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (addr_i)
                OFF_CTRL:   regs_d.div    = wdata_i[DIV_LSB +: DIV_W];
                OFF_PRE_LO: regs_d.pre_lo = wdata_i[HALF_W-1:0];
                OFF_PRE_HI: regs_d.pre_hi = wdata_i[HALF_W-1:0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_CTRL:    rdata_o[DIV_LSB +: DIV_W] = regs_q.div;
            OFF_LIVE_LO: rdata_o = count_i[HALF_W-1:0];
            OFF_LIVE_HI: rdata_o = count_i[CNT_W-1:HALF_W];
            OFF_PRE_LO:  rdata_o = regs_q.pre_lo;
            OFF_PRE_HI:  rdata_o = regs_q.pre_hi;
            OFF_SNAP_LO: rdata_o = snap_i[HALF_W-1:0];
            OFF_SNAP_HI: rdata_o = snap_i[CNT_W-1:HALF_W];
            default:     rdata_o = '0;
        endcase
    end

    assign div_o     = regs_q.div;
    assign preload_o = {regs_q.pre_hi, regs_q.pre_lo};
endmodule

// File: rtl/snap_counter64.sv
module snap_counter64
    import scnt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DIV_W-1:0] div_w;
    logic [CNT_W-1:0] pre_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] snap_w;
    logic             load_w;
    logic             latch_w;
    logic             tick_w;

    scnt_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .count_i   (count_w),
        .snap_i    (snap_w),
        .rdata_o   (bus_rdata),
        .div_o     (div_w),
        .preload_o (pre_w),
        .load_o    (load_w),
        .latch_o   (latch_w)
    );

    scnt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_w),
        .restart_i (load_w),
        .tick_o    (tick_w)
    );

    scnt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_w),
        .load_i    (load_w),
        .latch_i   (latch_w),
        .preload_i (pre_w),
        .count_o   (count_w),
        .snap_o    (snap_w)
    );
endmodule

// File: rtl/snap_counter64_chk.sv
module snap_counter64_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load,
    input logic             latch,
    input logic [CNT_W-1:0] preload,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] snap
);
    // R4: snapshot captures the count of the command cycle
    a_r4_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> snap == $past(count));

    // R5: load replaces the count with the staged preload
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(preload));

    // R6: snapshot only changes on a snapshot command
    a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(snap));

    // R2/R3: a divider step adds exactly one, with wrap
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> count == $past(count) + 1'b1);

    // R2: without a step or load the count holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R7: the two commands never fire together
    a_r7_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load, latch}) <= 1);
endmodule

bind snap_counter64 snap_counter64_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .load    (load_w),
    .latch   (latch_w),
    .preload (pre_w),
    .count   (count_w),
    .snap    (snap_w)
);

// File: tb/snap_counter64_tb.sv
`timescale 1ns/1ps
module snap_counter64_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    snap_counter64 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write presented for one edge; returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int unsigned edge_no);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        edge_no = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic rd64(input logic [7:0] lo_a, output logic [63:0] v);
        logic [31:0] hi, lo;
        rd(lo_a + 8'h04, hi);
        rd(lo_a, lo);
        v = {hi, lo};
    endtask

    function automatic logic [63:0] expect_at(logic [63:0] p, int unsigned n, int unsigned d);
        return p + 64'(n / (d + 1));
    endfunction

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v32;
        logic [63:0] v64, snap_exp, pval;
        int unsigned ld, se, dummy;
        int unsigned divs [5] = '{0, 1, 2, 3, 7};
        logic [63:0] pres [3] = '{64'h0, 64'h0000_0000_FFFF_FFFD, 64'h1234_5678_9ABC_DEF0};

        repeat (3) @(negedge clk);
        // R1: everything reads zero under reset
        for (int a = 0; a <= 8'h18; a += 4) begin
            rd(8'(a), v32);
            chk("R1 reset read", {32'h0, v32}, 64'h0);
        end
        rst_n = 1'b1;

        foreach (divs[i]) begin
            foreach (pres[j]) begin
                pval = pres[j];
                wr(8'h0C, pval[31:0], dummy);
                wr(8'h10, pval[63:32], dummy);
                rd(8'h0C, v32); chk("R8 preload lo readback", {32'h0, v32}, {32'h0, pval[31:0]});
                rd(8'h10, v32); chk("R8 preload hi readback", {32'h0, v32}, {32'h0, pval[63:32]});
                wr(8'h00, (divs[i] << 16) | 32'h3, ld);
                // R5/R2/R3: count follows preload + floor(n/(D+1))
                for (int k = 0; k < 3 * (divs[i] + 1) + 2; k++) begin
                    if (k > 0) @(negedge clk);
                    rd64(8'h04, v64);
                    chk("R2 R5 R3 live count", v64, expect_at(pval, cyc - ld, divs[i]));
                end
                // R4: snapshot at an arbitrary phase
                wr(8'h00, (divs[i] << 16) | 32'h1, se);
                snap_exp = expect_at(pval, se - 1 - ld, divs[i]);
                rd64(8'h14, v64); chk("R4 snapshot value", v64, snap_exp);
                rd64(8'h04, v64); chk("R7 counting after snapshot", v64, expect_at(pval, cyc - ld, divs[i]));
                rd(8'h00, v32); chk("R7 ctrl readback", {32'h0, v32}, {32'h0, divs[i] << 16});
                // R7: bit1 alone is not a command
                wr(8'h00, (divs[i] << 16) | 32'h2, dummy);
                rd64(8'h04, v64); chk("R7 bit1-only write", v64, expect_at(pval, cyc - ld, divs[i]));
                // R8: live words ignore writes
                wr(8'h04, 32'hDEAD_BEEF, dummy);
                wr(8'h08, 32'hCAFE_F00D, dummy);
                rd64(8'h04, v64); chk("R8 live write ignored", v64, expect_at(pval, cyc - ld, divs[i]));
                wr(8'h14, 32'h5555_AAAA, dummy);
                // R6: snapshot survives preload writes and a load
                wr(8'h0C, 32'h0BAD_0BAD, dummy);
                wr(8'h00, (divs[i] << 16) | 32'h3, dummy);
                rd64(8'h14, v64); chk("R6 snapshot held", v64, snap_exp);
            end
        end

        // R3: wrap from all ones, every clock
        wr(8'h0C, 32'hFFFF_FFFE, dummy);
        wr(8'h10, 32'hFFFF_FFFF, dummy);
        wr(8'h00, 32'h0000_0003, ld);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            rd64(8'h04, v64);
            chk("R3 wrap D0", v64, 64'hFFFF_FFFF_FFFF_FFFE + 64'(cyc - ld));
        end
        // R3: wrap with divider 1
        wr(8'h0C, 32'hFFFF_FFFF, dummy);
        wr(8'h00, 32'h0001_0003, ld);
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            rd64(8'h04, v64);
            chk("R3 wrap D1", v64, expect_at(64'hFFFF_FFFF_FFFF_FFFF, cyc - ld, 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule